// File: doc/BRIEF.md
# Secure Cache-Line Tag Policy Checker

This block sits beside an ordinary cache controller and decides, for each access, what the cache must do with the addressed line. The decision depends on the protected-execution mode, the kind of access, and the security tags stored with the line. It accepts one access at a time and reports one response. The response says whether the line is used as it is, or is evicted first and then refilled. It also says whether a refill is plain or verified by a MAC check, which tag the new line carries, and whether an exception is raised.

A hit whose tags do not suit the access is never served. The line is evicted instead: it is written back if dirty, and encrypted on the way out if it holds secure data. The access then proceeds as a miss. A verified fill raises `mac_req` and waits for the outcome of the integrity check. If the check fails, the line is not installed and the block raises an integrity exception. The data arrays, the replacement choice and the cryptographic engines stay outside the block.

The sequencer has four states:
- IDLE: ready for an access.
- EVAL: the decision is taken.
- WAIT_MAC: waiting for the verification result.
- DONE: the response is presented for one cycle.

The transitions are:
- IDLE→EVAL: an access is accepted.
- EVAL→DONE: the access is resolved without verification.
- EVAL→WAIT_MAC: a verified fill is needed.
- WAIT_MAC→DONE: the verification result arrives.
- DONE→IDLE: always, on the next cycle.

Top module: `sec_tag_policy`

## Requirements
- R1: After reset `ready`=1, `resp_valid`=0 and `mac_req`=0.
- R2: Instruction fetch (kind 0) in active mode (mode 01) uses a hit line only when it is tagged secure-instruction (`line_secure`=1, `line_is_instr`=1). Any other hit is evicted and refilled with verification, with target tag 1 (secure instruction).
- R3: Instruction fetch in mode 00 or 10, and normal load (kind 1) or store (kind 2) in modes 00, 01 and 10, behave alike. An untagged hit is used. A secure-tagged hit is evicted and refilled plainly (fill 1) with tag 0. A miss fills plainly, installs the line and sets tag 0.
- R4: A verified fill (fill 2) raises `mac_req` until `mac_valid`. On `mac_ok`=1 the line is installed with the target tag and exception 0.
- R5: On `mac_ok`=0 the line is not installed and the tag is 0. The exception is 4 for an instruction fetch and 5 for a secure data access.
- R6: A secure load (kind 3) or secure store (kind 4) in mode 01 uses a hit only when it is tagged secure-data (`line_secure`=1, `line_is_instr`=0). Otherwise it performs a verified fill with target tag 2 (secure data).
- R7: A secure load or store in any mode other than 01 raises exception 2. In that case there is no eviction, no fill and no install.
- R8: Mode 11, or an access kind of 5, 6 or 7, raises exception 2 with no action.
- R9: With `PHYS_TAGGED`=1, a secure hit whose `vtag_match`=0 is evicted and reloaded rather than used.
- R10: A nonzero `req_offset` raises exception 9 with no action.
- R11: When both the mode/access check and the alignment check fail, exception 2 is reported.
- R12: `resp_valid` is a one-cycle pulse. It comes 2 cycles after the accepting edge when no verification is needed, and 1 cycle after `mac_valid` is sampled otherwise.
- R13: An evicted hit sets `resp_writeback` exactly when the line is dirty. It sets `resp_encrypt` exactly when the written-back line is tagged secure-data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access offered (taken when `ready`) |
| req_kind | input | 3 | 0 fetch, 1 load, 2 store, 3 secure load, 4 secure store |
| cur_mode | input | 2 | 00 normal, 01 active protected, 10 suspended, 11 reserved |
| line_hit | input | 1 | Lookup hit |
| line_secure | input | 1 | Line carries a security tag |
| line_is_instr | input | 1 | Tag kind: 1 instruction, 0 data |
| line_dirty | input | 1 | Line is modified |
| vtag_match | input | 1 | Stored virtual tag matches the access |
| req_offset | input | OFFSET_BITS | Byte offset within the word |
| ready | output | 1 | Block can accept an access |
| mac_req | output | 1 | Verified fill pending, awaiting result |
| mac_valid | input | 1 | Verification result present |
| mac_ok | input | 1 | Verification passed |
| resp_valid | output | 1 | Response pulse |
| resp_evict | output | 1 | Evict the hit line |
| resp_writeback | output | 1 | Write back the evicted line |
| resp_encrypt | output | 1 | Encrypt the written-back line |
| resp_fill | output | 2 | 0 none, 1 plain, 2 verified |
| resp_install | output | 1 | Place the filled line in the cache |
| resp_tag | output | 2 | 0 none, 1 secure instruction, 2 secure data |
| resp_exc | output | 4 | 0 none, 2 access, 4 code integrity, 5 data integrity, 9 unaligned |

## Verification
A captured request field that is corrupted shows up at the ports in the DONE cycle of that same access: it yields a wrong action, tag or exception code. A sequencer stuck in the wrong state shows up within a cycle or two. It appears as a `mac_req` that never rises or never falls, a response pulse at the wrong latency, or a `ready` that stays low. Integrity failures matter most. An installed line or a leftover tag after a failed MAC check would let unverified content pass as protected, so every failure path is compared field by field.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam logic [2:0] K_IFETCH = 3'd0;
    localparam logic [2:0] K_LOAD   = 3'd1;
    localparam logic [2:0] K_STORE  = 3'd2;
    localparam logic [2:0] K_SLOAD  = 3'd3;
    localparam logic [2:0] K_SSTORE = 3'd4;

    localparam logic [1:0] M_NORMAL = 2'b00;
    localparam logic [1:0] M_ACTIVE = 2'b01;
    localparam logic [1:0] M_SUSP   = 2'b10;
    localparam logic [1:0] M_RSVD   = 2'b11;

    localparam logic [3:0] EXC_NONE      = 4'd0;
    localparam logic [3:0] EXC_ACCESS    = 4'd2;
    localparam logic [3:0] EXC_CODE      = 4'd4;
    localparam logic [3:0] EXC_DATA      = 4'd5;
    localparam logic [3:0] EXC_UNALIGNED = 4'd9;

    typedef enum logic [1:0] {
        FILL_NONE     = 2'd0,
        FILL_PLAIN    = 2'd1,
        FILL_VERIFIED = 2'd2
    } fill_e;

    typedef enum logic [1:0] {
        TAG_NONE      = 2'd0,
        TAG_SEC_INSTR = 2'd1,
        TAG_SEC_DATA  = 2'd2
    } tag_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVAL,
        S_WAIT_MAC,
        S_DONE
    } state_e;

    typedef struct packed {
        logic [2:0] kind;
        logic [1:0] mode;
        logic       hit;
        logic       sec;
        logic       instr;
        logic       dirty;
        logic       vmatch;
        logic       misal;
    } req_t;

    typedef struct packed {
        logic       evict;
        logic       wb;
        logic       enc;
        fill_e      fill;
        tag_e       target;
        logic [3:0] exc;
    } plan_t;

endpackage

// File: rtl/stp_classify.sv
module stp_classify
    import stp_pkg::*;
#(
    parameter bit PHYS_TAGGED = 1'b1
) (
    input  req_t  rq,
    output plan_t pl
);

    logic vt_ok;

    generate
        if (PHYS_TAGGED) begin : g_phys
            assign vt_ok = rq.vmatch;
        end else begin : g_virt
            assign vt_ok = rq.vmatch | 1'b1;
        end
    endgenerate

    logic  secure_kind;
    logic  known_kind;
    logic  bad_mode;
    logic  good_hit;
    fill_e fill_kind;
    tag_e  want_tag;

    assign secure_kind = (rq.kind == K_SLOAD) || (rq.kind == K_SSTORE);
    assign known_kind  = (rq.kind <= K_SSTORE);
    assign bad_mode    = (rq.mode == M_RSVD) || (secure_kind && rq.mode != M_ACTIVE);

    always_comb begin
        if (rq.kind == K_IFETCH && rq.mode == M_ACTIVE) begin
            want_tag  = TAG_SEC_INSTR;
            fill_kind = FILL_VERIFIED;
            good_hit  = rq.sec & rq.instr & vt_ok;
        end else if (secure_kind) begin
            want_tag  = TAG_SEC_DATA;
            fill_kind = FILL_VERIFIED;
            good_hit  = rq.sec & ~rq.instr & vt_ok;
        end else begin
            want_tag  = TAG_NONE;
            fill_kind = FILL_PLAIN;
            good_hit  = ~rq.sec;
        end
    end

    always_comb begin
        pl = '0;
        if (!known_kind || bad_mode) begin
            pl.exc = EXC_ACCESS;
        end else if (rq.misal) begin
            pl.exc = EXC_UNALIGNED;
        end else if (!(rq.hit && good_hit)) begin
            pl.fill   = fill_kind;
            pl.target = want_tag;
            pl.evict  = rq.hit;
            pl.wb     = rq.hit & rq.dirty;
            pl.enc    = rq.hit & rq.dirty & rq.sec & ~rq.instr;
        end
    end

endmodule

// File: rtl/stp_seq.sv
module stp_seq
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  req_t       req_in,
    input  plan_t      pl,
    input  logic       mac_valid,
    input  logic       mac_ok,
    output req_t       cur,
    output logic       ready,
    output logic       mac_req,
    output logic       resp_valid,
    output logic       r_evict,
    output logic       r_wb,
    output logic       r_enc,
    output fill_e      r_fill,
    output logic       r_install,
    output tag_e       r_tag,
    output logic [3:0] r_exc
);

    state_e state, nxt;
    tag_e   r_target;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (req_valid) nxt = S_EVAL;
            S_EVAL:     nxt = (pl.exc == EXC_NONE && pl.fill == FILL_VERIFIED) ? S_WAIT_MAC : S_DONE;
            S_WAIT_MAC: if (mac_valid) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            r_evict   <= 1'b0;
            r_wb      <= 1'b0;
            r_enc     <= 1'b0;
            r_fill    <= FILL_NONE;
            r_install <= 1'b0;
            r_tag     <= TAG_NONE;
            r_target  <= TAG_NONE;
            r_exc     <= EXC_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) cur <= req_in;
                S_EVAL: begin
                    r_evict   <= pl.evict;
                    r_wb      <= pl.wb;
                    r_enc     <= pl.enc;
                    r_fill    <= pl.fill;
                    r_target  <= pl.target;
                    r_exc     <= pl.exc;
                    r_tag     <= TAG_NONE;
                    r_install <= (pl.exc == EXC_NONE) && (pl.fill == FILL_PLAIN);
                end
                S_WAIT_MAC: if (mac_valid) begin
                    r_install <= mac_ok;
                    r_tag     <= mac_ok ? r_target : TAG_NONE;
                    r_exc     <= mac_ok ? EXC_NONE
                               : ((r_target == TAG_SEC_INSTR) ? EXC_CODE : EXC_DATA);
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        ready      = (state == S_IDLE);
        mac_req    = (state == S_WAIT_MAC);
        resp_valid = (state == S_DONE);
    end

endmodule

// File: rtl/sec_tag_policy.sv
module sec_tag_policy
    import stp_pkg::*;
#(
    parameter int OFFSET_BITS = 3,
    parameter bit PHYS_TAGGED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [2:0]             req_kind,
    input  logic [1:0]             cur_mode,
    input  logic                   line_hit,
    input  logic                   line_secure,
    input  logic                   line_is_instr,
    input  logic                   line_dirty,
    input  logic                   vtag_match,
    input  logic [OFFSET_BITS-1:0] req_offset,
    output logic                   ready,
    output logic                   mac_req,
    input  logic                   mac_valid,
    input  logic                   mac_ok,
    output logic                   resp_valid,
    output logic                   resp_evict,
    output logic                   resp_writeback,
    output logic                   resp_encrypt,
    output logic [1:0]             resp_fill,
    output logic                   resp_install,
    output logic [1:0]             resp_tag,
    output logic [3:0]             resp_exc
);

    req_t  req_in, cur;
    plan_t pl;
    fill_e fill_q;
    tag_e  tag_q;

    assign req_in = '{kind: req_kind, mode: cur_mode, hit: line_hit, sec: line_secure,
                      instr: line_is_instr, dirty: line_dirty, vmatch: vtag_match,
                      misal: |req_offset};

    stp_classify #(.PHYS_TAGGED(PHYS_TAGGED)) u_classify (
        .rq (cur),
        .pl (pl)
    );

    stp_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .pl         (pl),
        .mac_valid  (mac_valid),
        .mac_ok     (mac_ok),
        .cur        (cur),
        .ready      (ready),
        .mac_req    (mac_req),
        .resp_valid (resp_valid),
        .r_evict    (resp_evict),
        .r_wb       (resp_writeback),
        .r_enc      (resp_encrypt),
        .r_fill     (fill_q),
        .r_install  (resp_install),
        .r_tag      (tag_q),
        .r_exc      (resp_exc)
    );

    assign resp_fill = fill_q;
    assign resp_tag  = tag_q;

endmodule

// File: rtl/stp_check.sv
module stp_check (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       mac_req,
    input logic       mac_valid,
    input logic       resp_valid,
    input logic       resp_evict,
    input logic       resp_writeback,
    input logic       resp_encrypt,
    input logic [1:0] resp_fill,
    input logic       resp_install,
    input logic [1:0] resp_tag,
    input logic [3:0] resp_exc
);

    assert_access_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_exc == 4'd2 |-> !resp_evict && resp_fill == 2'd0 && !resp_install && resp_tag == 2'd0);

    assert_unaligned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_exc == 4'd9 |-> !resp_evict && resp_fill == 2'd0 && !resp_install);

    assert_integrity_no_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && (resp_exc == 4'd4 || resp_exc == 4'd5) |-> !resp_install && resp_tag == 2'd0 && resp_fill == 2'd2);

    assert_mac_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req && !mac_valid |=> mac_req);

    assert_tag_needs_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_tag != 2'd0 |-> resp_install && resp_fill == 2'd2);

    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && ready);

    assert_writeback_evicts_R13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_writeback |-> resp_evict);

    assert_encrypt_writes_R13: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_encrypt |-> resp_writeback);

endmodule

bind sec_tag_policy stp_check u_stp_check (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready          (ready),
    .mac_req        (mac_req),
    .mac_valid      (mac_valid),
    .resp_valid     (resp_valid),
    .resp_evict     (resp_evict),
    .resp_writeback (resp_writeback),
    .resp_encrypt   (resp_encrypt),
    .resp_fill      (resp_fill),
    .resp_install   (resp_install),
    .resp_tag       (resp_tag),
    .resp_exc       (resp_exc)
);

// File: tb/test_sec_tag_policy.sv
module test_sec_tag_policy;

    localparam int OB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic [1:0] cur_mode = '0;
    logic line_hit = 1'b0, line_secure = 1'b0, line_is_instr = 1'b0, line_dirty = 1'b0, vtag_match = 1'b0;
    logic [OB-1:0] req_offset = '0;
    logic mac_valid = 1'b0, mac_ok = 1'b0;
    logic ready, mac_req, resp_valid, resp_evict, resp_writeback, resp_encrypt, resp_install;
    logic [1:0] resp_fill, resp_tag;
    logic [3:0] resp_exc;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sec_tag_policy #(.OFFSET_BITS(OB), .PHYS_TAGGED(1'b1)) i_sec_tag_policy (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind), .cur_mode(cur_mode),
        .line_hit(line_hit), .line_secure(line_secure), .line_is_instr(line_is_instr),
        .line_dirty(line_dirty), .vtag_match(vtag_match), .req_offset(req_offset),
        .ready(ready), .mac_req(mac_req), .mac_valid(mac_valid), .mac_ok(mac_ok),
        .resp_valid(resp_valid), .resp_evict(resp_evict), .resp_writeback(resp_writeback),
        .resp_encrypt(resp_encrypt), .resp_fill(resp_fill), .resp_install(resp_install),
        .resp_tag(resp_tag), .resp_exc(resp_exc)
    );

    // {need_mac, evict, wb, enc, fill[1:0], install, tag[1:0], exc[3:0]}
    function automatic logic [12:0] model(input logic [2:0] k, input logic [1:0] m, input logic h, s, i, d, v, mis, ok);
        logic need = 0, ev = 0, wb = 0, en = 0, inst = 0, good;
        logic [1:0] fl = 0, tg = 0, want, fk;
        logic [3:0] ex = 0;
        if (k > 3'd4 || m == 2'b11 || ((k == 3'd3 || k == 3'd4) && m != 2'b01)) ex = 4'd2;
        else if (mis) ex = 4'd9;
        else begin
            if (k == 3'd0 && m == 2'b01) begin want = 2'd1; fk = 2'd2; good = s && i && v; end
            else if (k >= 3'd3)          begin want = 2'd2; fk = 2'd2; good = s && !i && v; end
            else                         begin want = 2'd0; fk = 2'd1; good = !s; end
            if (!(h && good)) begin
                fl = fk; ev = h; wb = h && d; en = wb && s && !i;
                if (fk == 2'd1) inst = 1'b1;
                else begin
                    need = 1'b1; inst = ok; tg = ok ? want : 2'd0;
                    ex = ok ? 4'd0 : ((want == 2'd1) ? 4'd4 : 4'd5);
                end
            end
        end
        return {need, ev, wb, en, fl, inst, tg, ex};
    endfunction

    function automatic string label(input logic [2:0] k, input logic [1:0] m, input logic mis);
        if (k > 3'd4 || m == 2'b11) return "R8";
        if ((k == 3'd3 || k == 3'd4) && m != 2'b01) return (mis ? "R11" : "R7");
        if (mis) return "R10";
        if (k == 3'd0 && m == 2'b01) return "R2";
        if (k >= 3'd3) return "R6";
        return "R3";
    endfunction

    task automatic run(input logic [2:0] k, input logic [1:0] m, input logic h, s, i, d, v,
                       input logic [OB-1:0] off, input logic ok, input string rq);
        logic [12:0] exp, act;
        int lat;
        logic saw;
        exp = model(k, m, h, s, i, d, v, |off, ok);
        while (!ready) @(negedge clk);
        req_valid = 1; req_kind = k; cur_mode = m; line_hit = h; line_secure = s;
        line_is_instr = i; line_dirty = d; vtag_match = v; req_offset = off;
        @(negedge clk);
        req_valid = 0; lat = 1; saw = 0;
        while (!resp_valid && lat < 20) begin
            if (mac_req) begin saw = 1; mac_valid = 1; mac_ok = ok; end
            else mac_valid = 0;
            @(negedge clk);
            lat++;
        end
        mac_valid = 0;
        act = {saw, resp_evict, resp_writeback, resp_encrypt, resp_fill, resp_install, resp_tag, resp_exc};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s kind=%0d mode=%0d actual=%b expected=%b", rq, k, m, act, exp);
        end
        checks++;
        if (lat != (exp[12] ? 3 : 2)) begin
            fails++;
            $display("FAIL R12 latency actual=%0d expected=%0d", lat, exp[12] ? 3 : 2);
        end
        @(negedge clk);
    endtask

    initial begin
        #3000000;
        fails++;
        $display("FAIL R12 watchdog actual=hung expected=response");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (!(ready === 1'b1 && resp_valid === 1'b0 && mac_req === 1'b0)) begin
            fails++;
            $display("FAIL R1 reset actual=%b%b%b expected=100", ready, resp_valid, mac_req);
        end
        // R2 directed
        run(0, 1, 1, 1, 1, 0, 1, 0, 1, "R2");
        run(0, 1, 1, 0, 0, 1, 1, 0, 1, "R2");
        run(0, 1, 1, 1, 0, 1, 1, 0, 1, "R13");
        // R4 / R5
        run(3, 1, 0, 0, 0, 0, 1, 0, 1, "R4");
        run(0, 1, 0, 0, 0, 0, 1, 0, 0, "R5");
        run(4, 1, 0, 0, 0, 0, 1, 0, 0, "R5");
        // R3
        run(1, 0, 1, 1, 0, 1, 1, 0, 1, "R3");
        run(0, 2, 0, 0, 0, 0, 0, 0, 1, "R3");
        run(2, 1, 1, 0, 0, 1, 0, 0, 1, "R3");
        run(0, 0, 1, 1, 1, 1, 1, 0, 1, "R3");
        // R6
        run(4, 1, 1, 1, 0, 0, 1, 0, 1, "R6");
        run(3, 1, 1, 0, 0, 0, 1, 0, 1, "R6");
        run(3, 1, 1, 1, 1, 1, 1, 0, 1, "R6");
        // R7, R8
        run(3, 0, 1, 1, 0, 1, 1, 0, 1, "R7");
        run(4, 2, 0, 0, 0, 0, 1, 0, 1, "R7");
        run(0, 3, 1, 1, 1, 0, 1, 0, 1, "R8");
        run(6, 1, 0, 0, 0, 0, 1, 0, 1, "R8");
        // R9, R10, R11
        run(3, 1, 1, 1, 0, 1, 0, 0, 1, "R9");
        run(0, 1, 1, 1, 1, 0, 0, 0, 0, "R9");
        run(1, 0, 0, 0, 0, 0, 0, 3'd1, 1, "R10");
        run(3, 0, 0, 0, 0, 0, 1, 3'd3, 1, "R11");
        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [2:0] k;
            logic [1:0] m;
            logic [OB-1:0] off;
            k = 3'($urandom % 6);
            m = 2'($urandom % 4);
            off = ($urandom % 5 == 0) ? OB'($urandom) : '0;
            run(k, m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom % 4 != 0), off, 1'($urandom % 3 != 0), label(k, m, |off));
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule